// File: doc/BRIEF.md
# Priority Flow Control Transmit Requester with Refresh Timer

This block sits on the transmit side of an Ethernet MAC and decides when a priority flow control frame must go out. Buffer logic drives one congestion (xoff) request bit per traffic class. Whenever that vector changes while transmit generation is enabled, the block asks the frame builder for one frame. Each frame request carries the MAC-control opcode 0x0101, a class-enable vector with all eight classes set (0x00FF) and the current per-class xoff bits. Serialisation and CRC are left to the frame builder.

Receivers drop a pause state once its quanta run out. While congestion lasts, the block therefore repeats the last frame after a programmable number of quanta. One quantum is 512 bit times, counted on a bit-time tick input, so the spacing does not depend on link speed. The recommended period value is 0x8000 quanta. Repeats also require the resend enable and the generate request, and the disable input must be low. A force-Xon control makes the link start in the Xon state when transmit generation is switched on. Saturating counters record Xon frames and Xoff frames separately, and a total is reported as their sum.

The control word uses these bits:
- bit 1: transmit generation enable.
- bit 2: force Xon.
- bit 5: statistics enable.

Bits 0 and 3 (receive handling and eight-class mode) serve other paths and have no effect here.

Top module: `pfc_tx_refresh`

## Requirements
- R1: While reset is held, and after release while transmit generation (control bit 1) is low, no frame is requested and both counters read zero.
- R2: With control bit 1 set and force Xon (bit 2) clear, a change of `xoff_req` requests exactly one frame, with `frame_valid` high in the cycle after the change and `frame_xoff` equal to the new vector. Every frame carries opcode 0x0101 and class enable 0xFF.
- R3: When control bits 1 and 2 first become set together, one frame with all xoff bits zero (Xon) is requested in the next cycle. While bit 2 stays set, `xoff_req` changes request nothing. Clearing bit 2 requests a frame carrying the pending vector.
- R4: While control bit 1 is low, no frame is requested and the sent state returns to all-zero. On re-enable, a non-zero request therefore produces a frame.
- R5: A resend of the last vector is requested after `refresh_quanta` quanta of `BITS_PER_QUANTUM` (512) ticks. The count starts from the last frame, or from the cycle in which all resend gates became true. With a tick every cycle, the resend appears 512*P+1 cycles after that point.
- R6: No resend is requested while `resend_en` is low, `pp_gen` is low, `pp_disable` is high, or `refresh_quanta` is zero.
- R7: A sent state with all xoff bits clear is never resent.
- R8: The refresh timer advances only in cycles where `bit_tick` is high.
- R9: With statistics (control bit 5) set, each all-zero frame adds one to `xon_sent` and each other frame adds one to `xoff_sent`. Each counter stops at its maximum. With bit 5 clear, frames are not counted.
- R10: `total_sent` always equals `xon_sent + xoff_sent`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_tick | input | 1 | One pulse per bit time on the line |
| ctl_word | input | 8 | Control: bit 1 transmit enable, bit 2 force Xon, bit 5 statistics |
| resend_en | input | 1 | Enable for automatic periodic resend |
| pp_gen | input | 1 | Generate request; resend only while high |
| pp_disable | input | 1 | Resend blocked while high |
| refresh_quanta | input | QW | Resend period in 512-bit-time quanta, 0 = no resend |
| xoff_req | input | NUM_CLASSES | Per-class congestion request |
| frame_valid | output | 1 | One-cycle frame request strobe |
| frame_opcode | output | 16 | MAC-control opcode of the frame (0x0101), 0 when idle |
| frame_class_en | output | NUM_CLASSES | Class-enable vector (all ones), 0 when idle |
| frame_xoff | output | NUM_CLASSES | Per-class xoff bits of the requested frame |
| xon_sent | output | CNT_W | Saturating count of Xon frames |
| xoff_sent | output | CNT_W | Saturating count of frames with any xoff bit |
| total_sent | output | CNT_W+1 | Sum of the two counters |

## Verification
The assertions assume a synchronous environment: `ctl_word`, `xoff_req` and the resend gates change only between clock edges, and the control word stays stable across reset release. The stimulus meets this by changing every input on the falling edge. It changes the control word and the request vector only in deliberate steps, waits a full refresh period plus margin between steps, and keeps the resend gates constant while a resend interval is being timed, so each frame's cycle can be predicted exactly.

// File: rtl/pfc_tx_pkg.sv
package pfc_tx_pkg;

  localparam logic [15:0] PFC_OPCODE = 16'h0101;

  localparam int CTL_TX_EN    = 1;
  localparam int CTL_FORCE_ON = 2;
  localparam int CTL_STATS_EN = 5;

  typedef enum logic { KIND_XON = 1'b0, KIND_XOFF = 1'b1 } pfc_kind_e;

  function automatic pfc_kind_e pfc_kind(input logic any_xoff);
    return any_xoff ? KIND_XOFF : KIND_XON;
  endfunction

endpackage

// File: rtl/pfc_quanta_timer.sv
module pfc_quanta_timer #(
  parameter int BITS_PER_QUANTUM = 512,
  parameter int QW               = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bit_tick,
  input  logic          run,
  input  logic          restart,
  input  logic [QW-1:0] period,
  output logic [QW-1:0] quanta,
  output logic          expired
);
  localparam int BW = (BITS_PER_QUANTUM > 1) ? $clog2(BITS_PER_QUANTUM) : 1;
  localparam logic [BW-1:0] LAST_BIT = BW'(BITS_PER_QUANTUM - 1);

  logic [BW-1:0] bit_cnt;
  logic          quantum_done;

  assign quantum_done = bit_tick && (bit_cnt == LAST_BIT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bit_cnt <= '0;
      quanta  <= '0;
    end else if (restart || !run) begin
      bit_cnt <= '0;
      quanta  <= '0;
    end else if (quantum_done) begin
      bit_cnt <= '0;
      if (quanta != '1) quanta <= quanta + QW'(1);
    end else if (bit_tick) begin
      bit_cnt <= bit_cnt + BW'(1);
    end
  end

  assign expired = run && (period != '0) && (quanta >= period);

endmodule

// File: rtl/pfc_frame_sched.sv
module pfc_frame_sched #(
  parameter int NC = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tx_en,
  input  logic          force_xon,
  input  logic [NC-1:0] xoff_req,
  input  logic          expired,
  output logic          send,
  output logic [NC-1:0] send_vec,
  output logic [NC-1:0] state,
  output logic          resend_fire,
  output logic          force_active
);
  logic          force_seen;
  logic          force_rise;
  logic          change;
  logic [NC-1:0] eff_req;

  assign force_active = tx_en && force_xon;
  assign force_rise   = force_active && !force_seen;
  assign eff_req      = force_active ? '0 : xoff_req;
  assign change       = tx_en && (eff_req != state);
  assign resend_fire  = tx_en && !force_active && expired && (state != '0) && !change;
  assign send         = force_rise || change || resend_fire;
  assign send_vec     = eff_req;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      force_seen <= 1'b0;
      state      <= '0;
    end else begin
      force_seen <= force_active;
      state      <= tx_en ? eff_req : '0;
    end
  end

endmodule

// File: rtl/pfc_sat_counter.sv
module pfc_sat_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  output logic [W-1:0] count
);
  function automatic logic [W-1:0] sat_inc(input logic [W-1:0] v);
    return (v == '1) ? v : v + W'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n)   count <= '0;
    else if (inc) count <= sat_inc(count);
  end

endmodule

// File: rtl/pfc_tx_refresh.sv
module pfc_tx_refresh
  import pfc_tx_pkg::*;
#(
  parameter int NUM_CLASSES      = 8,
  parameter int CNT_W            = 16,
  parameter int QW               = 16,
  parameter int BITS_PER_QUANTUM = 512
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   bit_tick,
  input  logic [7:0]             ctl_word,
  input  logic                   resend_en,
  input  logic                   pp_gen,
  input  logic                   pp_disable,
  input  logic [QW-1:0]          refresh_quanta,
  input  logic [NUM_CLASSES-1:0] xoff_req,
  output logic                   frame_valid,
  output logic [15:0]            frame_opcode,
  output logic [NUM_CLASSES-1:0] frame_class_en,
  output logic [NUM_CLASSES-1:0] frame_xoff,
  output logic [CNT_W-1:0]       xon_sent,
  output logic [CNT_W-1:0]       xoff_sent,
  output logic [CNT_W:0]         total_sent
);
  logic tx_en, force_xon, stats_en;
  logic unused_ctl;

  assign tx_en      = ctl_word[CTL_TX_EN];
  assign force_xon  = ctl_word[CTL_FORCE_ON];
  assign stats_en   = ctl_word[CTL_STATS_EN];
  assign unused_ctl = ^{ctl_word[0], ctl_word[3], ctl_word[4], ctl_word[7:6]};

  logic                   sched_send;
  logic [NUM_CLASSES-1:0] sched_vec;
  logic [NUM_CLASSES-1:0] sched_state;
  logic                   resend_fire;
  logic                   force_active;
  logic                   tmr_run;
  logic                   tmr_expired;
  logic [QW-1:0]          tmr_quanta;
  pfc_kind_e              frame_kind;

  assign tmr_run = tx_en && resend_en && pp_gen && !pp_disable &&
                   !force_active && (sched_state != '0);

  pfc_quanta_timer #(
    .BITS_PER_QUANTUM(BITS_PER_QUANTUM),
    .QW              (QW)
  ) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .bit_tick(bit_tick),
    .run     (tmr_run),
    .restart (sched_send),
    .period  (refresh_quanta),
    .quanta  (tmr_quanta),
    .expired (tmr_expired)
  );

  pfc_frame_sched #(.NC(NUM_CLASSES)) u_sched (
    .clk         (clk),
    .rst_n       (rst_n),
    .tx_en       (tx_en),
    .force_xon   (force_xon),
    .xoff_req    (xoff_req),
    .expired     (tmr_expired),
    .send        (sched_send),
    .send_vec    (sched_vec),
    .state       (sched_state),
    .resend_fire (resend_fire),
    .force_active(force_active)
  );

  assign frame_kind = pfc_kind(|sched_vec);

  logic [CNT_W-1:0] kind_cnt [2];

  for (genvar k = 0; k < 2; k++) begin : g_cnt
    pfc_sat_counter #(.W(CNT_W)) u_cnt (
      .clk  (clk),
      .rst_n(rst_n),
      .inc  (sched_send && stats_en &&
             (frame_kind == ((k == 0) ? KIND_XON : KIND_XOFF))),
      .count(kind_cnt[k])
    );
  end

  assign xon_sent   = kind_cnt[0];
  assign xoff_sent  = kind_cnt[1];
  assign total_sent = {1'b0, kind_cnt[0]} + {1'b0, kind_cnt[1]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      frame_valid    <= 1'b0;
      frame_opcode   <= '0;
      frame_class_en <= '0;
      frame_xoff     <= '0;
    end else begin
      frame_valid    <= sched_send;
      frame_opcode   <= sched_send ? PFC_OPCODE : '0;
      frame_class_en <= sched_send ? '1 : '0;
      if (sched_send) frame_xoff <= sched_vec;
    end
  end

endmodule

// File: rtl/pfc_tx_refresh_chk.sv
module pfc_tx_refresh_chk #(
  parameter int NC = 8,
  parameter int CW = 16,
  parameter int QW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bit_tick,
  input logic          tx_bit,
  input logic          force_bit,
  input logic          resend_en,
  input logic          pp_gen,
  input logic          pp_disable,
  input logic [QW-1:0] refresh_quanta,
  input logic          frame_valid,
  input logic [15:0]   frame_opcode,
  input logic [NC-1:0] frame_class_en,
  input logic [NC-1:0] frame_xoff,
  input logic [CW-1:0] xon_sent,
  input logic [CW-1:0] xoff_sent,
  input logic [CW:0]   total_sent,
  input logic          resend_fire,
  input logic          tmr_run,
  input logic          tmr_restart,
  input logic [QW-1:0] tmr_quanta,
  input logic [NC-1:0] sched_state
);

  p_frame_fields_r2: assert property (@(posedge clk) disable iff (!rst_n)
    frame_valid |-> (frame_opcode == 16'h0101 && frame_class_en == '1));

  p_force_xon_frame_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_bit && force_bit) |=> (frame_valid && frame_xoff == '0));

  p_no_frame_when_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
    frame_valid |-> $past(tx_bit));

  p_resend_gates_r6: assert property (@(posedge clk) disable iff (!rst_n)
    resend_fire |-> (resend_en && pp_gen && !pp_disable && refresh_quanta != '0));

  p_xon_not_resent_r7: assert property (@(posedge clk) disable iff (!rst_n)
    resend_fire |-> (sched_state != '0));

  p_tick_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (tmr_run && !tmr_restart && !bit_tick) |=> $stable(tmr_quanta));

  p_counts_follow_frames_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (xon_sent != $past(xon_sent) || xoff_sent != $past(xoff_sent)) |-> frame_valid);

  p_total_sum_r10: assert property (@(posedge clk) disable iff (!rst_n)
    total_sent == ({1'b0, xon_sent} + {1'b0, xoff_sent}));

endmodule

bind pfc_tx_refresh pfc_tx_refresh_chk #(
  .NC(NUM_CLASSES),
  .CW(CNT_W),
  .QW(QW)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .bit_tick      (bit_tick),
  .tx_bit        (tx_en),
  .force_bit     (force_xon),
  .resend_en     (resend_en),
  .pp_gen        (pp_gen),
  .pp_disable    (pp_disable),
  .refresh_quanta(refresh_quanta),
  .frame_valid   (frame_valid),
  .frame_opcode  (frame_opcode),
  .frame_class_en(frame_class_en),
  .frame_xoff    (frame_xoff),
  .xon_sent      (xon_sent),
  .xoff_sent     (xoff_sent),
  .total_sent    (total_sent),
  .resend_fire   (resend_fire),
  .tmr_run       (tmr_run),
  .tmr_restart   (sched_send),
  .tmr_quanta    (tmr_quanta),
  .sched_state   (sched_state)
);

// File: tb/pfc_tx_refresh_tb_top.sv
module pfc_tx_refresh_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int QB         = 512;
  localparam int CW         = 3;
  localparam int CMAX       = 7;
  localparam int GAP        = 2 * QB + 1;
  localparam int WATCHDOG   = 50000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        bit_tick;
  logic [7:0]  ctl_word;
  logic        resend_en, pp_gen, pp_disable;
  logic [15:0] refresh_quanta;
  logic [7:0]  xoff_req;
  logic        frame_valid;
  logic [15:0] frame_opcode;
  logic [7:0]  frame_class_en, frame_xoff;
  logic [CW-1:0] xon_sent, xoff_sent;
  logic [CW:0]   total_sent;

  pfc_tx_refresh #(.CNT_W(CW)) dut_i (
    .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .ctl_word(ctl_word),
    .resend_en(resend_en), .pp_gen(pp_gen), .pp_disable(pp_disable),
    .refresh_quanta(refresh_quanta), .xoff_req(xoff_req),
    .frame_valid(frame_valid), .frame_opcode(frame_opcode),
    .frame_class_en(frame_class_en), .frame_xoff(frame_xoff),
    .xon_sent(xon_sent), .xoff_sent(xoff_sent), .total_sent(total_sent)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  logic [7:0] q_vec [$];
  int         q_cyc [$];
  string      q_tag [$];
  int checks = 0, errors = 0;
  int m_xon = 0, m_xoff = 0;
  bit done = 1'b0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic report();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  // scoreboard monitor
  always @(posedge clk) begin
    #1;
    if (rst_n && frame_valid) begin
      if (q_vec.size() == 0) begin
        chk(1'b0, "R4 R6 R7", "unexpected frame", frame_xoff, 0);
      end else begin
        logic [7:0] ev;
        int ec;
        string et;
        ev = q_vec.pop_front();
        ec = q_cyc.pop_front();
        et = q_tag.pop_front();
        chk(frame_xoff == ev, et, "frame xoff vector", frame_xoff, ev);
        chk(cyc == ec, et, "frame cycle", cyc, ec);
      end
      chk(frame_opcode == 16'h0101, "R2", "opcode", frame_opcode, 16'h0101);
      chk(frame_class_en == 8'hFF, "R2", "class enable", frame_class_en, 8'hFF);
      if (ctl_word[5]) begin
        if (frame_xoff == 8'h00) m_xon  = (m_xon  < CMAX) ? m_xon + 1 : CMAX;
        else                     m_xoff = (m_xoff < CMAX) ? m_xoff + 1 : CMAX;
      end
    end
  end

  always @(posedge clk) begin
    if (cyc >= WATCHDOG && !done) begin
      checks++;
      errors++;
      $display("FAIL R5 watchdog: cycle=%0d expected below %0d", cyc, WATCHDOG);
      report();
      $finish;
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_at(input logic [7:0] v, input int at, input string tag);
    q_vec.push_back(v);
    q_cyc.push_back(at);
    q_tag.push_back(tag);
  endtask

  task automatic drive_xoff(input logic [7:0] v, input bit exp, input string tag);
    xoff_req = v;
    if (exp) expect_at(v, cyc + 1, tag);
  endtask

  task automatic idle_window(input int n, input string tag);
    step(n);
    chk(q_vec.size() == 0, tag, "pending expected frames", q_vec.size(), 0);
  endtask

  task automatic check_counts(input string tag);
    chk(xon_sent == m_xon[CW-1:0], tag, "xon count", xon_sent, m_xon);
    chk(xoff_sent == m_xoff[CW-1:0], tag, "xoff count", xoff_sent, m_xoff);
    chk(total_sent == CW'(0) + m_xon + m_xoff, "R10", "total count",
        total_sent, m_xon + m_xoff);
  endtask

  initial begin
    int k, n;
    rst_n = 1'b0; bit_tick = 1'b1; ctl_word = 8'h00;
    resend_en = 1'b0; pp_gen = 1'b0; pp_disable = 1'b0;
    refresh_quanta = 16'd0; xoff_req = 8'h00;
    step(3);
    // R1: reset state
    chk(frame_valid == 1'b0, "R1", "frame_valid in reset", frame_valid, 0);
    chk(xon_sent == 0 && xoff_sent == 0, "R1", "counters in reset",
        {xon_sent, xoff_sent}, 0);
    rst_n = 1'b1;
    xoff_req = 8'h05;
    step(4);
    chk(frame_valid == 1'b0, "R1", "no frame while disabled", frame_valid, 0);
    check_counts("R1");

    // R3: force Xon at enable
    ctl_word = 8'h26;
    expect_at(8'h00, cyc + 1, "R3");
    step(4);
    drive_xoff(8'h07, 1'b0, "R3");
    idle_window(4, "R3");
    ctl_word = 8'h22;
    expect_at(8'h07, cyc + 1, "R3");
    step(3);

    // R2: change-driven frames
    drive_xoff(8'h85, 1'b1, "R2");
    step(3);
    drive_xoff(8'h00, 1'b1, "R2");
    step(3);
    check_counts("R9");

    // R4: disabled transmit
    ctl_word = 8'h20;
    step(1);
    drive_xoff(8'h33, 1'b0, "R4");
    idle_window(5, "R4");
    check_counts("R4");
    ctl_word = 8'h22;
    expect_at(8'h33, cyc + 1, "R4");
    step(3);

    // R9: statistics disabled
    ctl_word = 8'h02;
    drive_xoff(8'h00, 1'b1, "R9");
    step(3);
    check_counts("R9");
    ctl_word = 8'h22;
    step(2);

    // R5: periodic resend
    refresh_quanta = 16'd2; pp_gen = 1'b1; pp_disable = 1'b0; resend_en = 1'b1;
    step(2);
    k = cyc + 1;
    drive_xoff(8'h10, 1'b1, "R2");
    expect_at(8'h10, k + GAP, "R5");
    expect_at(8'h10, k + 2 * GAP, "R5");
    while (cyc < k + 2 * GAP + 10) step(1);
    pp_disable = 1'b1;
    idle_window(1200, "R6");
    n = cyc;
    pp_disable = 1'b0;
    expect_at(8'h10, n + GAP, "R5");
    while (cyc < n + GAP + 5) step(1);
    pp_gen = 1'b0;
    idle_window(1200, "R6");
    pp_gen = 1'b1;
    drive_xoff(8'h00, 1'b1, "R7");
    idle_window(1200, "R7");
    check_counts("R9");

    // R8: tick gating
    bit_tick = 1'b0;
    drive_xoff(8'h02, 1'b1, "R8");
    idle_window(1200, "R8");
    n = cyc;
    bit_tick = 1'b1;
    expect_at(8'h02, n + GAP, "R8");
    while (cyc < n + GAP + 5) step(1);
    resend_en = 1'b0;
    idle_window(1200, "R6");
    resend_en = 1'b1;
    refresh_quanta = 16'd0;
    drive_xoff(8'h04, 1'b1, "R6");
    idle_window(1200, "R6");

    // R9: saturation, R10 totals
    check_counts("R9");
    chk(xoff_sent == CW'(CMAX), "R9", "saturated xoff count", xoff_sent, CMAX);
    done = 1'b1;
    report();
    $finish;
  end

endmodule